// File: doc/BRIEF.md
# Receive FIFO with Programmable Trigger and Flow-Control Levels

This block is the receive half of a serial port. A line receiver hands it complete bytes through a one-cycle valid strobe. The block queues them in a 16-entry byte FIFO and shows the oldest byte on a CPU read port. A one-cycle pop strobe removes that byte.

A control word holds two encoded fields. The trigger field sets the fill level at which the block reports "trigger reached" instead of "data ready". The two flags are never both high. The flow-control field sets the fill level at which the "can accept" output drops, so the far end can be told to hold off. When a byte arrives with no free slot, the byte is discarded and a sticky overrun flag is raised. A line-status read returns that flag and clears it.

The flags come straight from the fill count and the control word. They are valid in the cycle after the push or pop edge that changed the count.

Top module: `rx_fifo_level`

## Requirements
- R1: After reset the fill count is 0, data-ready and trigger-reached are 0, overrun is 0, can-accept is 1, the read port shows 0 and the control word reads 0.
- R2: Each accepted byte raises the fill count by one, and bytes leave in arrival order. The read port always shows the oldest stored byte.
- R3: A pop removes the oldest byte, and the read position wraps after the 16th slot. With the FIFO empty the read port shows 0, and a pop changes nothing.
- R4: Control bits 8:7 select the trigger level: code 0 is 1, code 1 is 4, code 2 is 8 and code 3 is 14. While the count is at or above that level, trigger-reached is 1 and data-ready is 0.
- R5: While the count is below the trigger level, trigger-reached is 0, and data-ready is 1 exactly when the count is non-zero.
- R6: Control bits 11:9 select the flow-control threshold. Codes 0 to 7 give 15, 1, 4, 6, 8, 10, 12 and 14. Can-accept is 1 exactly when the count is below that threshold.
- R7: A byte that arrives while 16 bytes are stored and no pop is requested is discarded. The count stays 16, the stored bytes are unchanged, and overrun becomes 1.
- R8: A line-status read returns overrun and clears it at the same edge. If a new overrun occurs in that same cycle, overrun stays 1.
- R9: A push and a pop in the same cycle leave the count unchanged, even when 16 bytes are stored. In that case the new byte is kept and no overrun is raised.
- R10: A control write stores the whole 12-bit word, which can be read back at once on the control read port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Byte from the line receiver is valid |
| in_byte | input | 8 | Received byte |
| cpu_pop | input | 1 | Remove the oldest byte |
| cpu_rdata | output | 8 | Oldest stored byte, 0 when empty |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 12 | Control word write data |
| ctl_rdata | output | 12 | Current control word |
| lsr_rd | input | 1 | Line-status read strobe (clears overrun) |
| lsr_ovr | output | 1 | Sticky overrun flag |
| st_ready | output | 1 | Data ready, below the trigger level |
| st_trig | output | 1 | Trigger level reached |
| fill_cnt | output | 5 | Number of stored bytes, 0 to 16 |
| rx_accept | output | 1 | Flow control: more bytes may be sent |

## Verification
Two pairs of functions can land in the same cycle.

The first pair is an overrun and a line-status read. The bench fills the FIFO, then drives a byte and the status read strobe together. It judges that the flag reads 1 afterwards, because the set wins over the clear.

The second pair is a push and a pop at a full FIFO. The bench drives both strobes together and checks three things: the count stays at 16, no overrun appears, and the new byte surfaces last when the queue is drained against a reference queue.

// File: rtl/rx_fifo_level_pkg.sv
package rx_fifo_level_pkg;

  // Control word field positions
  localparam int TRG_LSB = 7;
  localparam int TRG_W   = 2;
  localparam int FLW_LSB = 9;
  localparam int FLW_W   = 3;

  // Receive trigger level for a trigger field code
  function automatic int unsigned trig_level(input logic [TRG_W-1:0] code);
    int unsigned lvl;
    case (code)
      2'd0:    lvl = 1;
      2'd1:    lvl = 4;
      2'd2:    lvl = 8;
      default: lvl = 14;
    endcase
    return lvl;
  endfunction

  // Flow-control threshold: code 0 is the top level, then 1, then 4 and up in steps of 2
  function automatic int unsigned flow_level(input logic [FLW_W-1:0] code);
    int unsigned lvl;
    if (code == '0)
      lvl = 15;
    else if (code == 3'd1)
      lvl = 1;
    else
      lvl = 2 * int'(code);
    return lvl;
  endfunction

endpackage

// File: rtl/rxfl_store.sv
module rxfl_store #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic [DW-1:0] dout,
  output logic [CW-1:0] cnt,
  output logic          drop
);

  localparam logic [CW-1:0] FULL_C = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_I = AW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_idx, wr_idx_n;
  logic [AW-1:0] rd_idx, rd_idx_n;
  logic [CW-1:0] cnt_n;
  logic          empty, full, do_pop, do_push;

  always_comb begin
    empty    = (cnt == '0);
    full     = (cnt == FULL_C);
    do_pop   = pop && !empty;
    do_push  = push && (!full || do_pop);
    drop     = push && !do_push;
    wr_idx_n = wr_idx;
    rd_idx_n = rd_idx;
    cnt_n    = cnt;
    if (do_push)
      wr_idx_n = (wr_idx == LAST_I) ? '0 : wr_idx + AW'(1);
    if (do_pop)
      rd_idx_n = (rd_idx == LAST_I) ? '0 : rd_idx + AW'(1);
    if (do_push && !do_pop)
      cnt_n = cnt + CW'(1);
    else if (do_pop && !do_push)
      cnt_n = cnt - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_idx <= '0;
      rd_idx <= '0;
      cnt    <= '0;
    end else begin
      wr_idx <= wr_idx_n;
      rd_idx <= rd_idx_n;
      cnt    <= cnt_n;
    end
  end

  // Data array: no reset, written only with its enable
  always_ff @(posedge clk) begin
    if (do_push)
      mem[wr_idx] <= din;
  end

  assign dout = empty ? '0 : mem[rd_idx];

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULL_C); // R2
  AST_PUSH_INC: assert property (@(posedge clk) disable iff (!rst_n)
    push && !pop && (cnt != FULL_C) |=> cnt == $past(cnt) + CW'(1)); // R2
  AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
    pop && !push && (cnt == '0) |=> (cnt == '0) && $stable(rd_idx)); // R3
  AST_BOTH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    push && pop && (cnt != '0) |=> $stable(cnt)); // R9

endmodule

// File: rtl/rxfl_flags.sv
module rxfl_flags
  import rx_fifo_level_pkg::*;
#(
  parameter int CW = 5
) (
  input  logic [CW-1:0]    cnt,
  input  logic [TRG_W-1:0] trg_code,
  input  logic [FLW_W-1:0] flw_code,
  output logic             ready,
  output logic             trig,
  output logic             accept
);

  int unsigned trg_lvl, flw_lvl, cnt_u;

  always_comb begin
    cnt_u   = 32'(cnt);
    trg_lvl = trig_level(trg_code);
    flw_lvl = flow_level(flw_code);
    if (cnt_u >= trg_lvl) begin
      trig  = 1'b1;
      ready = 1'b0;
    end else begin
      trig  = 1'b0;
      ready = (cnt_u != 0);
    end
    accept = (cnt_u < flw_lvl);
  end

endmodule

// File: rtl/rxfl_ovr.sv
module rxfl_ovr (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);

  logic flag_n;

  always_comb begin
    flag_n = flag;
    if (set)
      flag_n = 1'b1;
    else if (clr)
      flag_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      flag <= 1'b0;
    else
      flag <= flag_n;
  end

  AST_LSR_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    clr && !set |=> !flag); // R8
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> flag); // R8

endmodule

// File: rtl/rx_fifo_level.sv
module rx_fifo_level
  import rx_fifo_level_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  parameter int CTL_W = 12,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_vld,
  input  logic [DW-1:0]    in_byte,
  input  logic             cpu_pop,
  output logic [DW-1:0]    cpu_rdata,
  input  logic             ctl_we,
  input  logic [CTL_W-1:0] ctl_wdata,
  output logic [CTL_W-1:0] ctl_rdata,
  input  logic             lsr_rd,
  output logic             lsr_ovr,
  output logic             st_ready,
  output logic             st_trig,
  output logic [CW-1:0]    fill_cnt,
  output logic             rx_accept
);

  localparam logic [CW-1:0] FULL_C = CW'(DEPTH);

  // Reset: asserted asynchronously, released on the clock
  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  // Control word
  logic [CTL_W-1:0] ctl_q, ctl_n;
  always_comb begin
    ctl_n = ctl_q;
    if (ctl_we)
      ctl_n = ctl_wdata;
  end
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)
      ctl_q <= '0;
    else
      ctl_q <= ctl_n;
  end
  assign ctl_rdata = ctl_q;

  logic drop;

  rxfl_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .push  (in_vld),
    .din   (in_byte),
    .pop   (cpu_pop),
    .dout  (cpu_rdata),
    .cnt   (fill_cnt),
    .drop  (drop)
  );

  rxfl_flags #(.CW(CW)) u_flags (
    .cnt      (fill_cnt),
    .trg_code (ctl_q[TRG_LSB +: TRG_W]),
    .flw_code (ctl_q[FLW_LSB +: FLW_W]),
    .ready    (st_ready),
    .trig     (st_trig),
    .accept   (rx_accept)
  );

  rxfl_ovr u_ovr (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .set   (drop),
    .clr   (lsr_rd),
    .flag  (lsr_ovr)
  );

  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(st_ready && st_trig)); // R4
  AST_READY_EMPTY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (fill_cnt == '0) |-> !st_ready && !st_trig); // R5
  AST_ACCEPT_TOP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (fill_cnt >= CW'(15)) |-> !rx_accept); // R6
  AST_DROP_SETS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_vld && !cpu_pop && (fill_cnt == FULL_C) |=> lsr_ovr && (fill_cnt == FULL_C)); // R7

endmodule

// File: tb/rx_fifo_level_bench.sv
module rx_fifo_level_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_vld, cpu_pop, ctl_we, lsr_rd;
  logic [7:0]  in_byte, cpu_rdata;
  logic [11:0] ctl_wdata, ctl_rdata;
  logic        lsr_ovr, st_ready, st_trig, rx_accept;
  logic [4:0]  fill_cnt;

  always #4 clk = ~clk;

  rx_fifo_level u_rx_fifo_level (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_byte(in_byte),
    .cpu_pop(cpu_pop), .cpu_rdata(cpu_rdata), .ctl_we(ctl_we),
    .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata), .lsr_rd(lsr_rd),
    .lsr_ovr(lsr_ovr), .st_ready(st_ready), .st_trig(st_trig),
    .fill_cnt(fill_cnt), .rx_accept(rx_accept)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;
  byte unsigned mq[$];
  logic m_ovr = 1'b0;

  // Vector: trigger code, flow code, bytes to load, expected ready, trig, accept
  localparam logic [12:0] VEC [12] = '{
    {2'd0, 3'd0, 5'd0,  1'b0, 1'b0, 1'b1},
    {2'd0, 3'd0, 5'd1,  1'b0, 1'b1, 1'b1},
    {2'd1, 3'd1, 5'd3,  1'b1, 1'b0, 1'b0},
    {2'd1, 3'd2, 5'd4,  1'b0, 1'b1, 1'b0},
    {2'd2, 3'd3, 5'd5,  1'b1, 1'b0, 1'b1},
    {2'd2, 3'd4, 5'd8,  1'b0, 1'b1, 1'b0},
    {2'd3, 3'd5, 5'd13, 1'b1, 1'b0, 1'b0},
    {2'd3, 3'd6, 5'd14, 1'b0, 1'b1, 1'b0},
    {2'd3, 3'd7, 5'd13, 1'b1, 1'b0, 1'b1},
    {2'd3, 3'd0, 5'd16, 1'b0, 1'b1, 1'b0},
    {2'd2, 3'd7, 5'd7,  1'b1, 1'b0, 1'b1},
    {2'd1, 3'd5, 5'd9,  1'b0, 1'b1, 1'b1}
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // One clock of stimulus; inputs change between edges, model updated from pre-state
  task automatic cyc(input logic p, input logic [7:0] b, input logic rd, input logic ls);
    int  pre;
    bit  setv;
    pre  = mq.size();
    setv = p && (pre == 16) && !rd;
    in_vld = p; in_byte = b; cpu_pop = rd; lsr_rd = ls;
    if (rd && pre > 0) void'(mq.pop_front());
    if (p && !setv) mq.push_back(b);
    if (setv) m_ovr = 1'b1;
    else if (ls) m_ovr = 1'b0;
    @(posedge clk); #1;
    in_vld = 1'b0; cpu_pop = 1'b0; lsr_rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic set_ctl(input logic [1:0] tc, input logic [2:0] fc);
    ctl_we = 1'b1;
    ctl_wdata = (12'(fc) << 9) | (12'(tc) << 7);
    @(posedge clk); #1;
    ctl_we = 1'b0;
    @(negedge clk);
  endtask

  task automatic check_model(input string tag);
    chk({tag, " count"}, int'(fill_cnt), mq.size());
    chk({tag, " head"}, int'(cpu_rdata), (mq.size() > 0) ? int'(mq[0]) : 0);
    chk({tag, " overrun"}, int'(lsr_ovr), int'(m_ovr));
  endtask

  task automatic drain(input string tag);
    while (mq.size() > 0) begin
      check_model(tag);
      cyc(1'b0, 8'h00, 1'b1, 1'b0);
    end
  endtask

  initial begin
    rst_n = 1'b0; in_vld = 1'b0; in_byte = '0; cpu_pop = 1'b0;
    ctl_we = 1'b0; ctl_wdata = '0; lsr_rd = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    chk("R1 count", int'(fill_cnt), 0);
    chk("R1 ready", int'(st_ready), 0);
    chk("R1 trig", int'(st_trig), 0);
    chk("R1 overrun", int'(lsr_ovr), 0);
    chk("R1 accept", int'(rx_accept), 1);
    chk("R1 rdata", int'(cpu_rdata), 0);
    chk("R1 ctl", int'(ctl_rdata), 0);

    // Table walk: R4, R5, R6, R10
    for (int i = 0; i < 12; i++) begin
      logic [12:0] v;
      v = VEC[i];
      set_ctl(v[12:11], v[10:8]);
      chk("R10 ctl readback", int'(ctl_rdata), int'((12'(v[10:8]) << 9) | (12'(v[12:11]) << 7)));
      drain("R3 drain");
      for (int k = 0; k < int'(v[7:3]); k++) cyc(1'b1, 8'(i * 16 + k), 1'b0, 1'b0);
      chk($sformatf("R2 vec%0d count", i), int'(fill_cnt), int'(v[7:3]));
      chk($sformatf("R4/R5 vec%0d ready", i), int'(st_ready), int'(v[2]));
      chk($sformatf("R4 vec%0d trig", i), int'(st_trig), int'(v[1]));
      chk($sformatf("R6 vec%0d accept", i), int'(rx_accept), int'(v[0]));
    end

    // R5: empty FIFO with highest trigger level
    set_ctl(2'd3, 3'd0);
    drain("R3 drain");
    chk("R5 empty ready", int'(st_ready), 0);
    cyc(1'b1, 8'h21, 1'b0, 1'b0);
    chk("R5 one byte ready", int'(st_ready), 1);
    chk("R5 one byte trig", int'(st_trig), 0);

    // R2/R3: order and index wrap
    set_ctl(2'd0, 3'd0);
    drain("R3 drain");
    for (int k = 0; k < 16; k++) cyc(1'b1, 8'(8'h40 + k), 1'b0, 1'b0);
    check_model("R2 full load");
    for (int k = 0; k < 5; k++) begin
      check_model("R3 pop");
      cyc(1'b0, 8'h00, 1'b1, 1'b0);
    end
    for (int k = 0; k < 5; k++) cyc(1'b1, 8'(8'h80 + k), 1'b0, 1'b0);
    check_model("R3 wrap load");
    drain("R3 wrap drain");
    chk("R3 empty rdata", int'(cpu_rdata), 0);
    cyc(1'b0, 8'h00, 1'b1, 1'b0);
    chk("R3 empty pop count", int'(fill_cnt), 0);
    chk("R3 empty pop rdata", int'(cpu_rdata), 0);
    cyc(1'b1, 8'h3C, 1'b0, 1'b0);
    check_model("R3 after empty pop");
    drain("R3 drain");

    // R7: overrun when full
    for (int k = 0; k < 16; k++) cyc(1'b1, 8'(8'h10 + k), 1'b0, 1'b0);
    cyc(1'b1, 8'hEE, 1'b0, 1'b0);
    chk("R7 count", int'(fill_cnt), 16);
    chk("R7 overrun", int'(lsr_ovr), 1);
    chk("R7 head", int'(cpu_rdata), 8'h10);

    // R8: read clears; set in same cycle wins
    cyc(1'b0, 8'h00, 1'b0, 1'b1);
    chk("R8 cleared", int'(lsr_ovr), 0);
    cyc(1'b1, 8'hEF, 1'b0, 1'b1);
    chk("R8 set wins", int'(lsr_ovr), 1);
    check_model("R8 contents");
    cyc(1'b0, 8'h00, 1'b0, 1'b1);
    chk("R8 cleared again", int'(lsr_ovr), 0);

    // R9: push and pop together at full, then partially filled
    cyc(1'b1, 8'h77, 1'b1, 1'b0);
    chk("R9 full count", int'(fill_cnt), 16);
    chk("R9 full no overrun", int'(lsr_ovr), 0);
    chk("R9 full head", int'(cpu_rdata), 8'h11);
    drain("R9 full drain");
    for (int k = 0; k < 3; k++) cyc(1'b1, 8'(8'h50 + k), 1'b0, 1'b0);
    cyc(1'b1, 8'h55, 1'b1, 1'b0);
    chk("R9 partial count", int'(fill_cnt), 3);
    check_model("R9 partial");
    drain("R9 partial drain");

    // R1: reset again mid-traffic
    for (int k = 0; k < 4; k++) cyc(1'b1, 8'(k), 1'b0, 1'b0);
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    mq.delete(); m_ovr = 1'b0;
    repeat (3) @(negedge clk);
    check_model("R1 re-reset");
    chk("R1 re-reset ctl", int'(ctl_rdata), 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
      $finish;
    end
  end

endmodule